// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that lets an external bus controller read and write a bank of 8-bit configuration registers, each selected by an 8-bit address. It works from a system clock. SCL and SDA arrive already synchronized to that clock, and the block drives SDA through an open-drain enable: when the enable is high, the pad pulls the line low. The block detects start, repeated start and stop conditions and compares the received device address with its own. It keeps an 8-bit register pointer. It performs writes and combined-format reads.

The device address has a fixed upper nibble and a lower part taken from three strap inputs. A write transaction sends the device address, then a pointer byte, then any number of data bytes. Each data byte produces a one-cycle write strobe to the register file. For a combined read, the controller sets the pointer, issues a repeated start and readdresses the target for reading. The target then shifts out the register that the pointer selects. The pointer survives repeated starts and stops, so the controller can read the same register again or switch direction without setting the pointer again. The register file is read through a combinational address/data pair.

Top module: `i2c_cfg_target`

## Requirements
- R1: While rst_ni is low, sda_oe_o and reg_we_o are low.
- R2: An address byte whose upper seven bits, sent MSB first, equal {4'b1001, strap_i[2:0]} (strap_i[0] is the address LSB) is acknowledged: SDA is held low for the ninth clock. Bit 0 of the address byte selects the direction, with 0 for write and 1 for read.
- R3: An address byte that does not match gets no acknowledge. The target then keeps SDA released and issues no write strobe until the next start or stop.
- R4: The first byte after a write-direction address is loaded into the register pointer, which appears on reg_raddr_o. The byte is acknowledged and produces no write strobe.
- R5: Each later byte in a write-direction phase is acknowledged. It produces a single one-cycle reg_we_o pulse, with reg_waddr_o set to the pointer and reg_wdata_o set to the byte. The pointer does not advance, so the last byte written is the one that stays.
- R6: After a read-direction address, the target shifts out reg_rdata_i for the pointer register, MSB first. It changes SDA only while SCL is low.
- R7: The pointer is kept across repeated starts and stops. Only a new write-direction pointer byte changes it.
- R8: If the controller acknowledges a read byte (SDA low in the ninth clock), the target sends the same register again in the next byte.
- R9: If the controller does not acknowledge a read byte, the target releases SDA and drives nothing until the next start or stop.
- R10: sda_oe_o changes only while SCL is low.
- R11: A stop condition returns the target to idle with SDA released. A byte cut short by a stop produces no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| strap_i | input | 3 | Low bits of the device address |
| sda_oe_o | output | 1 | Pull SDA low when high |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_waddr_o | output | 8 | Register write address |
| reg_wdata_o | output | 8 | Register write data |
| reg_raddr_o | output | 8 | Register read address (current pointer) |
| reg_rdata_i | input | 8 | Register read data for reg_raddr_o |

## Verification
The checks assume the following about the bus inputs:
- Each SCL level lasts several system clocks.
- The controller changes SDA during SCL high only to form a start or a stop.
- The controller never forms a start or stop while the target holds SDA low, so it ends every read with a not-acknowledge before it stops or restarts.

The bench meets these assumptions with a fixed quarter-bit spacing of five clocks. Its bit task changes SDA only after SCL has been low for a quarter bit. The line the bench feeds back is the wired-AND of the controller's drive and the target's enable.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges count as conditions only with SCL high on both samples
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         cnt_en_i,
  input  logic         cnt_clr_i,
  output logic [W-1:0] data_o,
  output logic         cnt_last_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  data_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (load_i) begin
      data_q <= load_val_i;
    end else if (shift_i) begin
      data_q <= {data_q[W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_clr_i) begin
      cnt_q <= '0;
    end else if (cnt_en_i) begin
      cnt_q <= (cnt_q == CW'(W - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign data_o     = data_q;
  assign cnt_last_o = (cnt_q == CW'(W - 1));
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned DEV_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              cnt_last_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  output logic              shift_en_o,
  output logic              shift_bit_o,
  output logic              load_en_o,
  output logic              cnt_en_o,
  output logic              cnt_clr_o,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic [BYTE_W-1:0] ptr_o
);
  tgt_state_e        state_q, state_d;
  logic              done_q, done_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              we_q, we_d;
  logic [BYTE_W-1:0] wdata_q, wdata_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              rx_phase;

  assign rx_phase = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WDATA);

  always_comb begin
    state_d     = state_q;
    done_d      = done_q;
    rw_d        = rw_q;
    mack_d      = mack_q;
    we_d        = 1'b0;
    wdata_d     = wdata_q;
    ptr_d       = ptr_q;
    shift_en_o  = 1'b0;
    shift_bit_o = sda_i;
    load_en_o   = 1'b0;
    cnt_en_o    = 1'b0;
    cnt_clr_o   = 1'b0;

    if (stop_i) begin
      state_d   = ST_IDLE;
      done_d    = 1'b0;
      cnt_clr_o = 1'b1;
    end else if (start_i) begin
      state_d   = ST_ADDR;
      done_d    = 1'b0;
      cnt_clr_o = 1'b1;
    end else if (rx_phase) begin
      if (scl_rise_i && !done_q) begin
        shift_en_o = 1'b1;
        cnt_en_o   = 1'b1;
        if (cnt_last_i) done_d = 1'b1;
      end else if (scl_fall_i && done_q) begin
        // byte complete: act on it once SCL is low
        done_d    = 1'b0;
        cnt_clr_o = 1'b1;
        if (state_q == ST_ADDR) begin
          if (rx_byte_i[BYTE_W-1:1] == dev_addr_i) begin
            rw_d    = rx_byte_i[0];
            state_d = ST_ADDR_ACK;
          end else begin
            state_d = ST_WAIT;
          end
        end else if (state_q == ST_PTR) begin
          ptr_d   = rx_byte_i;
          state_d = ST_PTR_ACK;
        end else begin
          we_d    = 1'b1;
          wdata_d = rx_byte_i;
          state_d = ST_WDATA_ACK;
        end
      end
    end else begin
      case (state_q)
        ST_ADDR_ACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              state_d   = ST_RDATA;
              load_en_o = 1'b1;
            end else begin
              state_d = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall_i) state_d = ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (cnt_last_i) begin
              state_d   = ST_RDATA_ACK;
              cnt_clr_o = 1'b1;
            end else begin
              shift_en_o  = 1'b1;
              shift_bit_o = 1'b1;
              cnt_en_o    = 1'b1;
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise_i) mack_d = ~sda_i;
          if (scl_fall_i) begin
            if (mack_q) begin
              state_d   = ST_RDATA;
              load_en_o = 1'b1;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      we_q    <= we_d;
      wdata_q <= wdata_d;
      ptr_q   <= ptr_d;
    end
  end

  // decoded from registered state and shift data; both move only after an SCL fall
  assign sda_oe_o = (state_q == ST_ADDR_ACK) || (state_q == ST_PTR_ACK) ||
                    (state_q == ST_WDATA_ACK) ||
                    ((state_q == ST_RDATA) && !rx_byte_i[BYTE_W-1]);
  assign we_o    = we_q;
  assign wdata_o = wdata_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter int unsigned   STRAP_W  = 3,
  parameter int unsigned   PREFIX_W = 4,
  parameter logic [PREFIX_W-1:0] PREFIX = 4'b1001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic              sda_oe_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_waddr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic [BYTE_W-1:0] reg_raddr_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int unsigned DEV_W = PREFIX_W + STRAP_W;

  logic scl_rise, scl_fall, start_c, stop_c;
  logic shift_en, shift_bit, load_en, cnt_en, cnt_clr, cnt_last;
  logic [BYTE_W-1:0] shreg, ptr;
  logic [DEV_W-1:0]  dev_addr;

  assign dev_addr = {PREFIX, strap_i};

  i2c_bus_events u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_byte_shifter #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift_en),
    .bit_i      (shift_bit),
    .load_i     (load_en),
    .load_val_i (reg_rdata_i),
    .cnt_en_i   (cnt_en),
    .cnt_clr_i  (cnt_clr),
    .data_o     (shreg),
    .cnt_last_o (cnt_last)
  );

  i2c_target_fsm #(.DEV_W(DEV_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_c),
    .stop_i      (stop_c),
    .sda_i       (sda_i),
    .rx_byte_i   (shreg),
    .cnt_last_i  (cnt_last),
    .dev_addr_i  (dev_addr),
    .shift_en_o  (shift_en),
    .shift_bit_o (shift_bit),
    .load_en_o   (load_en),
    .cnt_en_o    (cnt_en),
    .cnt_clr_o   (cnt_clr),
    .sda_oe_o    (sda_oe_o),
    .we_o        (reg_we_o),
    .wdata_o     (reg_wdata_o),
    .ptr_o       (ptr)
  );

  assign reg_waddr_o = ptr;
  assign reg_raddr_o = ptr;
endmodule

// File: rtl/i2c_cfg_target_chk.sv
module i2c_cfg_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input logic [7:0] reg_raddr_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!sda_oe_o && !reg_we_o);
    end
  end

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  p_we_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_scl_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !scl_i);

  p_ptr_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reg_raddr_o) |-> (!scl_i && !reg_we_o));

  p_stop_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(scl_i) && scl_i && !$past(sda_i) && sda_i) |=> (!sda_oe_o && !reg_we_o));
endmodule

bind i2c_cfg_target i2c_cfg_target_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_oe_o    (sda_oe_o),
  .reg_we_o    (reg_we_o),
  .reg_raddr_o (reg_raddr_o)
);

// File: tb/sim_i2c_cfg_target.sv
`timescale 1ns/1ps
module sim_i2c_cfg_target;
  localparam int Q = 5;
  localparam int NV = 6;
  localparam logic [2:0] V_STRAP [NV] = '{3'b000, 3'b111, 3'b101, 3'b010, 3'b001, 3'b100};
  localparam logic [7:0] V_PTR   [NV] = '{8'h00, 8'hFF, 8'h41, 8'h80, 8'h7E, 8'h40};
  localparam logic [7:0] V_DAT   [NV] = '{8'h5A, 8'hC3, 8'h3C, 8'h01, 8'hFE, 8'hA5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b000;
  logic sda_oe, we;
  logic [7:0] waddr, wdata, raddr, rdata;
  logic sda_bus;
  logic [7:0] rf [256];
  int we_cnt = 0;
  int checks = 0, errors = 0, oe_bad = 0;
  logic prev_oe = 1'b0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rdata   = rf[raddr];

  i2c_cfg_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe), .reg_we_o(we), .reg_waddr_o(waddr), .reg_wdata_o(wdata),
    .reg_raddr_o(raddr), .reg_rdata_i(rdata)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= 8'h00;
    end else if (we) begin
      rf[waddr] <= wdata;
      we_cnt    <= we_cnt + 1;
    end
  end

  // R10 monitor: enable must not move while SCL is high
  always @(posedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && scl_m) oe_bad <= oe_bad + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cyc(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input int n, input logic [7:0] v);
    logic s;
    for (int i = 7; i > 7 - n; i--) bit_cyc(v[i], s);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    send_bits(8, v);
    bit_cyc(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(1'b1, s);
      d[i] = s;
    end
    bit_cyc(~mack, s);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] st, input logic rd);
    return {4'b1001, st, rd};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d, d2;
    int base;

    tick(3);
    chk(!sda_oe && !we, "R1 reset outputs", {sda_oe, we}, 0);
    rst_n = 1'b1;
    tick(4);

    // table: write one register, then combined read back
    for (int k = 0; k < NV; k++) begin
      strap = V_STRAP[k];
      tick(2);
      base = we_cnt;
      i2c_start();
      send_byte(addr_byte(strap, 1'b0), ack);
      chk(ack, "R2 address ack", ack, 1);
      send_byte(V_PTR[k], ack);
      chk(ack && we_cnt == base, "R4 pointer ack no strobe", we_cnt - base, 0);
      chk(raddr == V_PTR[k], "R4 pointer value", raddr, V_PTR[k]);
      send_byte(V_DAT[k], ack);
      chk(ack && we_cnt == base + 1, "R5 one strobe", we_cnt - base, 1);
      chk(rf[V_PTR[k]] == V_DAT[k], "R5 written data", rf[V_PTR[k]], V_DAT[k]);
      i2c_stop();
      i2c_start();
      send_byte(addr_byte(strap, 1'b0), ack);
      send_byte(V_PTR[k], ack);
      i2c_start();
      send_byte(addr_byte(strap, 1'b1), ack);
      chk(ack, "R2 read address ack", ack, 1);
      read_byte(1'b0, d);
      chk(d == V_DAT[k], "R6 combined read", d, V_DAT[k]);
      i2c_stop();
    end

    // R3: wrong strap and wrong prefix
    strap = 3'b010;
    base = we_cnt;
    i2c_start();
    send_byte(addr_byte(3'b011, 1'b0), ack);
    chk(!ack, "R3 strap mismatch nack", ack, 0);
    send_byte(8'h99, ack);
    chk(!ack && we_cnt == base, "R3 ignored byte", we_cnt - base, 0);
    send_byte(8'h00, ack);
    chk(!ack && we_cnt == base, "R3 still ignored", we_cnt - base, 0);
    i2c_stop();
    i2c_start();
    send_byte({7'b1101010, 1'b0}, ack);
    chk(!ack, "R3 prefix mismatch nack", ack, 0);
    i2c_stop();

    // R7: pointer only, then reads across stops
    strap = 3'b100;
    i2c_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h41, ack);
    i2c_stop();
    i2c_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    read_byte(1'b0, d);
    chk(d == 8'h3C, "R7 pointer reload", d, 8'h3C);
    i2c_stop();
    i2c_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    read_byte(1'b0, d);
    chk(d == 8'h3C, "R7 pointer kept across stop", d, 8'h3C);
    i2c_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    read_byte(1'b0, d);
    chk(d == 8'h3C, "R7 pointer kept across restart", d, 8'h3C);

    // R8 / R9: ack repeats register, nack releases bus
    i2c_start();
    send_byte(addr_byte(strap, 1'b1), ack);
    read_byte(1'b1, d);
    read_byte(1'b0, d2);
    chk(d == 8'h3C && d2 == 8'h3C, "R8 repeat after ack", d2, 8'h3C);
    read_byte(1'b0, d);
    chk(d == 8'hFF, "R9 released after nack", d, 8'hFF);
    i2c_stop();

    // R5: two data bytes, no pointer advance
    base = we_cnt;
    i2c_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h10, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    i2c_stop();
    chk(we_cnt == base + 2, "R5 two strobes", we_cnt - base, 2);
    chk(rf[8'h10] == 8'h22, "R5 last byte wins", rf[8'h10], 8'h22);
    chk(rf[8'h11] == 8'h00, "R5 no pointer advance", rf[8'h11], 0);

    // R11: stop cuts a data byte
    base = we_cnt;
    i2c_start();
    send_byte(addr_byte(strap, 1'b0), ack);
    send_byte(8'h20, ack);
    send_bits(5, 8'hF0);
    i2c_stop();
    tick(2);
    chk(we_cnt == base, "R11 partial byte no strobe", we_cnt - base, 0);
    chk(!sda_oe, "R11 released at idle", sda_oe, 0);

    chk(oe_bad == 0, "R10 enable moved with SCL high", oe_bad, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule